// File: doc/BRIEF.md
# Character-Cell Raster Timing Generator

This block produces the sweep timing and refresh addressing for a text-mode raster display. It runs on the character clock, so one clock is one character cell. A character counter sets the line period. At each line end a scan-line counter (the row address) advances. At the last scan line of a character row, a character-row counter advances instead. The horizontal sync, vertical sync and display window are derived by comparing these counters with programmable values.

The frame is an integer number of character rows followed by a small number of extra scan lines, which gives fine control of the field rate. All settings are parallel inputs and are meant to be held steady while the block runs. Reset clears every counter. The first frame after reset is addressed from zero, and every later frame is addressed from the start-address input. The memory address and the row address keep running through blanking, so they can also drive refresh of dynamic memory. A one-cycle pulse marks the first character of each new frame for downstream blink logic.

Top module: `crt_raster_timer`

## Requirements
- R1: The character counter runs from 0 to `h_total` and then wraps, so a line lasts `h_total`+1 clocks. Within a line, `ma` rises by one (modulo 2^14) on every clock.
- R2: `hs` is high while the character count c satisfies `hs_pos` <= c < `hs_pos`+`hs_width`. With `hs_width` = 0, `hs` never goes high.
- R3: `vs` goes high at the first character of scan line 0 of character row `vs_pos`. It then stays high for exactly 16 scan lines, and the count continues across a frame boundary.
- R4: A frame is (`v_total`+1)·(`max_line`+1) + `v_adj` scan lines. In a normal row, `ra` counts 0..`max_line`. In the adjust lines, `ra` counts 0..`v_adj`-1.
- R5: Every scan line of a character row starts at the same row base address. The base of the next row is the current base plus `h_disp`. The adjust lines repeat the base that follows the last row.
- R6: After the first frame, every frame starts with `ma` equal to `start_addr`. Address arithmetic wraps at 14 bits.
- R7: `de` is high only when the character count is below `h_disp`, the row is below `v_disp`, and the line is not an adjust line.
- R8: `frame_start` is high for exactly the one clock that holds character 0 of scan line 0 of row 0 in each new frame.
- R9: While reset is low, `ma`, `ra`, `vs` and `frame_start` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_total | input | 8 | Characters per line minus one |
| h_disp | input | 8 | Displayed characters per line |
| hs_pos | input | 8 | Character count at which horizontal sync begins |
| hs_width | input | 4 | Horizontal sync width in characters; 0 disables it |
| v_total | input | 7 | Character rows per frame minus one |
| v_adj | input | 5 | Extra scan lines appended to the frame |
| v_disp | input | 7 | Displayed character rows |
| vs_pos | input | 7 | Character row at which vertical sync begins |
| max_line | input | 5 | Scan lines per character row minus one |
| start_addr | input | 14 | First refresh address of each frame |
| ma | output | 14 | Refresh memory address |
| ra | output | 5 | Row (scan line) address |
| hs | output | 1 | Horizontal sync, active high |
| vs | output | 1 | Vertical sync, active high |
| de | output | 1 | Display enable, active high |
| frame_start | output | 1 | One-clock pulse at the start of each frame |

## Verification
The bench checks every output on every clock, so a wrong internal state shows up quickly.

- A wrong character count shows in `hs` and `ma` within one line.
- A scan-line or row counter that is off by one shows in `ra` at the next line end, and in the row base address (`ma`) at the next row end.
- A mistake in the adjust logic or in the frame length first shows in `frame_start` and in the reload of `start_addr`, one frame later.
- A wrong vertical-sync length shows as a `vs` edge sixteen lines after it starts.

The bench runs several small configurations over more than two frames each. They include a zero sync width, zero adjust lines, single-line rows, and a start address near the top of the address space.

// File: rtl/crt_raster_timer.sv
module crt_raster_timer #(
  parameter int HW  = 8,
  parameter int VW  = 7,
  parameter int RW  = 5,
  parameter int AW  = 14,
  parameter int SWW = 4,
  parameter int VSL = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [HW-1:0]  h_total,
  input  logic [HW-1:0]  h_disp,
  input  logic [HW-1:0]  hs_pos,
  input  logic [SWW-1:0] hs_width,
  input  logic [VW-1:0]  v_total,
  input  logic [RW-1:0]  v_adj,
  input  logic [VW-1:0]  v_disp,
  input  logic [VW-1:0]  vs_pos,
  input  logic [RW-1:0]  max_line,
  input  logic [AW-1:0]  start_addr,
  output logic [AW-1:0]  ma,
  output logic [RW-1:0]  ra,
  output logic           hs,
  output logic           vs,
  output logic           de,
  output logic           frame_start
);
  localparam int VCW = (VSL > 1) ? $clog2(VSL) : 1;

  logic [HW-1:0]  hcnt;
  logic [VW-1:0]  row;
  logic           in_adj;
  logic [AW-1:0]  base;
  logic [VCW-1:0] vs_cnt;

  logic           line_end, row_last, adj_last, last_row, frame_end, enter_adj, row_adv;
  logic [RW-1:0]  ra_n;
  logic [VW-1:0]  row_n;
  logic           adj_n;
  logic [AW-1:0]  base_n;
  logic [HW:0]    hs_end;

  assign line_end  = (hcnt == h_total);
  assign row_last  = (ra == max_line);
  assign adj_last  = (ra == v_adj - 1'b1);
  assign last_row  = row_last && (row == v_total);
  assign frame_end = in_adj ? adj_last : (last_row && (v_adj == '0));
  assign enter_adj = !in_adj && last_row && (v_adj != '0);
  assign row_adv   = !in_adj && row_last;

  always_comb begin
    ra_n   = (frame_end || row_adv) ? '0 : ra + 1'b1;
    row_n  = frame_end ? '0 : ((row_adv && !enter_adj) ? row + 1'b1 : row);
    adj_n  = enter_adj ? 1'b1 : (frame_end ? 1'b0 : in_adj);
    base_n = frame_end ? start_addr : (row_adv ? base + AW'(h_disp) : base);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt        <= '0;
      ra          <= '0;
      row         <= '0;
      in_adj      <= 1'b0;
      base        <= '0;
      ma          <= '0;
      vs          <= 1'b0;
      vs_cnt      <= '0;
      frame_start <= 1'b0;
    end else begin
      frame_start <= line_end && frame_end;
      if (line_end) begin
        hcnt   <= '0;
        ra     <= ra_n;
        row    <= row_n;
        in_adj <= adj_n;
        base   <= base_n;
        ma     <= base_n;
        if (row_n == vs_pos && ra_n == '0 && !adj_n) begin
          vs     <= 1'b1;
          vs_cnt <= '0;
        end else if (vs) begin
          if (vs_cnt == VCW'(VSL - 1)) vs <= 1'b0;
          else vs_cnt <= vs_cnt + 1'b1;
        end
      end else begin
        hcnt <= hcnt + 1'b1;
        ma   <= ma + 1'b1;
      end
    end
  end

  assign hs_end = {1'b0, hs_pos} + (HW+1)'(hs_width);
  assign hs = (hs_width != '0) && (hcnt >= hs_pos) && ({1'b0, hcnt} < hs_end);
  assign de = (hcnt < h_disp) && (row < v_disp) && !in_adj;

  AST_HCNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (hcnt == '0)); // R1
  AST_MA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> (ma == $past(ma) + 1'b1)); // R1
  AST_RA_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !in_adj |-> (ra <= max_line)); // R4
  AST_FS_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (hcnt == '0 && ra == '0 && row == '0 && !in_adj)); // R8
  AST_FS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && $stable(start_addr)) |-> (ma == start_addr)); // R6
  AST_ADJ_NO_DE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_adj && $past(in_adj)) |-> !de); // R7
  AST_LINE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && !row_last && !in_adj) |=> (ma == base)); // R5
endmodule

// File: tb/crt_raster_timer_tb_top.sv
module crt_raster_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  h_total, h_disp, hs_pos;
  logic [3:0]  hs_width;
  logic [6:0]  v_total, v_disp, vs_pos;
  logic [4:0]  v_adj, max_line;
  logic [13:0] start_addr;
  logic [13:0] ma;
  logic [4:0]  ra;
  logic        hs, vs, de, frame_start;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  crt_raster_timer dut_i (
    .clk(clk), .rst_n(rst_n), .h_total(h_total), .h_disp(h_disp), .hs_pos(hs_pos),
    .hs_width(hs_width), .v_total(v_total), .v_adj(v_adj), .v_disp(v_disp),
    .vs_pos(vs_pos), .max_line(max_line), .start_addr(start_addr),
    .ma(ma), .ra(ra), .hs(hs), .vs(vs), .de(de), .frame_start(frame_start)
  );

  task automatic check(input string req, input int act, input int exp, input int n);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, n, act, exp);
    end
  endtask

  task automatic run_cfg(input int ht, input int hd, input int hp, input int hw,
                         input int vt, input int va, input int vd, input int vp,
                         input int ml, input int sa, input int frames);
    int lpr, nrow_lines, flines, llen, total;
    rst_n = 1'b0;
    h_total = 8'(ht); h_disp = 8'(hd); hs_pos = 8'(hp); hs_width = 4'(hw);
    v_total = 7'(vt); v_adj = 5'(va); v_disp = 7'(vd); vs_pos = 7'(vp);
    max_line = 5'(ml); start_addr = 14'(sa);
    @(negedge clk); @(negedge clk);
    check("R9 ma", int'(ma), 0, -1);
    check("R9 ra", int'(ra), 0, -1);
    check("R9 vs", int'(vs), 0, -1);
    check("R9 frame_start", int'(frame_start), 0, -1);
    rst_n = 1'b1;
    lpr = ml + 1;
    nrow_lines = (vt + 1) * lpr;
    flines = nrow_lines + va;
    llen = ht + 1;
    total = frames * flines * llen;
    for (int n = 0; n < total; n++) begin
      int li, h, fi, lf, row, era, base, adj, eds, ehs, evs, efs;
      li = n / llen; h = n % llen;
      fi = li / flines; lf = li % flines;
      adj = (lf >= nrow_lines);
      if (adj) begin row = vt; era = lf - nrow_lines; end
      else begin row = lf / lpr; era = lf % lpr; end
      base = ((fi == 0) ? 0 : sa) + (adj ? (vt + 1) : row) * hd;
      eds = (h < hd) && (row < vd) && !adj;
      ehs = (hw != 0) && (h >= hp) && (h < hp + hw);
      evs = 0;
      for (int f = fi - 1; f <= fi; f++) begin
        int s;
        s = f * flines + vp * lpr;
        if (f >= 0 && s > 0 && li >= s && li - s < 16) evs = 1;
      end
      efs = (h == 0) && (lf == 0) && (li > 0);
      check("R1/R5/R6 ma", int'(ma), (base + h) % 16384, n);
      check("R4 ra", int'(ra), era, n);
      check("R2 hs", int'(hs), ehs, n);
      check("R3 vs", int'(vs), evs, n);
      check("R7 de", int'(de), eds, n);
      check("R8 frame_start", int'(frame_start), efs, n);
      @(negedge clk);
    end
  endtask

  initial begin
    h_total = '0; h_disp = '0; hs_pos = '0; hs_width = '0; v_total = '0;
    v_adj = '0; v_disp = '0; vs_pos = '0; max_line = '0; start_addr = '0;
    @(negedge clk);
    // adjust lines, 14-bit address wrap near top of space
    run_cfg(9, 6, 7, 2, 4, 2, 3, 4, 2, 16378, 3);
    // zero sync width, no adjust, one scan line per row
    run_cfg(5, 3, 4, 0, 19, 0, 15, 16, 0, 100, 3);
    // widest sync, long adjust, five lines per row
    run_cfg(30, 8, 10, 15, 3, 5, 2, 2, 4, 4660, 3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000ns;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule